// File: doc/BRIEF.md
# Return-Address Stack with Quad Spill

This block keeps the most recent return addresses of a processor core in a handful of on-chip registers. A call pushes an address; a return pops one. When a push arrives and every on-chip level is occupied, the block writes the four oldest entries to shared memory as one 128-bit quad, then stacks the new address. When a pop arrives and nothing is held on chip, it reads the most recently written quad back and returns its top word. Software sees a stack that is as deep as the memory area behind it, while most calls and returns complete in a single cycle with no memory traffic.

A spill pointer register marks where the next quad is written. It moves up by 16 bytes after each spill and down by 16 bytes before each refill, so a refill always reads back the quad that the last spill wrote. While a memory transfer is in flight, `busy` is high and the requester keeps its request asserted until it is taken. A second, single-entry return target (the link register) can be selected per request. It bypasses the stack and the memory entirely. The on-chip depth is a parameter, 4 by default; 8 is the wider build. A spill always moves exactly one quad of the oldest entries.

Top module: `retstack_spill`

## Requirements
- R1: After reset `busy`, `mem_req`, `pop_valid` and `collide_err` are low, the stack is empty and `ptr_value` equals the `BASE` parameter.
- R2: Stack pushes and pops (with `use_link` low) return addresses in last-in first-out order; a pop taken at a clock edge presents its address on `pop_addr` with `pop_valid` high for the cycle that follows that edge.
- R3: A stack push taken while all levels are full issues one memory write at `ptr_value`, with the oldest entry in bits 31:0 and the fourth oldest in bits 127:96. `ptr_value` grows by 16 when the write is acknowledged, and the pushed address is then on top of the stack.
- R4: A stack pop taken while the stack is empty issues one memory read at `ptr_value - 16` and sets `ptr_value` to that address when the read is acknowledged. It returns bits 127:96 of the read data on `pop_addr`, and leaves the other three words on the stack in their original order.
- R5: `busy` is high from the edge after a request that starts a transfer until the edge after `mem_ack`. Requests held during that time are not taken and not lost: they are taken at the first edge where `busy` is low. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R6: `push_req` and `pop_req` together in one cycle: the pop is performed, the push is discarded, and `collide_err` is high for the following cycle.
- R7: With `use_link` high, a push writes the link register and a pop returns it. The stack contents, the pointer and the memory port are left untouched.
- R8: `ptr_load` taken while `busy` is low sets `ptr_value` to `ptr_load_val` on the next edge. Stack requests in that same cycle are not taken.
- R9: Repeated spills and refills across several quads preserve full last-in first-out order and return the pointer to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request, held until taken |
| pop_req | input | 1 | Pop request, held until taken |
| use_link | input | 1 | Direct this request at the link register instead of the stack |
| push_addr | input | AW | Return address to push |
| pop_addr | output | AW | Popped return address |
| pop_valid | output | 1 | `pop_addr` is valid this cycle |
| collide_err | output | 1 | Push and pop arrived together in the previous cycle |
| busy | output | 1 | Memory transfer in progress; requests stall |
| ptr_load | input | 1 | Load the spill pointer |
| ptr_load_val | input | PW | Value for the spill pointer |
| ptr_value | output | PW | Current spill pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | PW | Memory byte address of the quad |
| mem_wdata | output | QW | Quad written on a spill |
| mem_rdata | input | QW | Quad returned on a refill |
| mem_ack | input | 1 | Memory completes the request |

## Verification
The bench builds the block with the default four-level stack, 32-bit entries, a 128-bit quad and a spill base of 0x100. It connects a memory model that acknowledges two cycles after each request. With only four levels, the fifth push already spills, so single spills, back-to-back spills over three quads and refills down to the base address all fit in short directed sequences. The two-cycle acknowledge keeps `busy` high long enough for a held request to stall. Reloading the pointer to 0x200 shows that the spill address follows the loaded value.

// File: rtl/retstack_pkg.sv
package retstack_pkg;

  typedef enum logic [2:0] {
    LOP_NONE,
    LOP_PUSH,
    LOP_POP,
    LOP_SPILL_PUSH,
    LOP_FILL_POP
  } lifo_op_e;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_SPILL,
    MS_FILL
  } mem_state_e;

endpackage

// File: rtl/retstack_lifo.sv
module retstack_lifo
  import retstack_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 4,
  parameter int QE    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  lifo_op_e         op,
  input  logic [AW-1:0]    push_val,
  input  logic [QE*AW-1:0] fill_quad,
  output logic [AW-1:0]    top_val,
  output logic [QE*AW-1:0] spill_quad,
  output logic             full,
  output logic             empty
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] ent [DEPTH];
  logic [CW-1:0] count;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] top_idx;

  assign wr_idx  = count[IW-1:0];
  assign top_idx = IW'(count - 1'b1);
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign top_val = ent[top_idx];

  always_comb begin
    for (int i = 0; i < QE; i++) begin
      spill_quad[i*AW +: AW] = ent[i];
    end
  end

  // occupancy
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case (op)
        LOP_PUSH:       count <= count + 1'b1;
        LOP_POP:        count <= count - 1'b1;
        LOP_SPILL_PUSH: count <= CW'(DEPTH - QE + 1);
        LOP_FILL_POP:   count <= CW'(QE - 1);
        default:        count <= count;
      endcase
    end
  end

  // entry storage, no reset needed: occupancy guards every read
  always_ff @(posedge clk) begin
    case (op)
      LOP_PUSH: ent[wr_idx] <= push_val;
      LOP_SPILL_PUSH: begin
        for (int i = 0; i < DEPTH - QE; i++) begin
          ent[i] <= ent[i + QE];
        end
        ent[DEPTH - QE] <= push_val;
      end
      LOP_FILL_POP: begin
        for (int i = 0; i < QE; i++) begin
          ent[i] <= fill_quad[i*AW +: AW];
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/retstack_mem_fsm.sv
module retstack_mem_fsm
  import retstack_pkg::*;
#(
  parameter int          QW     = 128,
  parameter int          PW     = 32,
  parameter int          QBYTES = 16,
  parameter logic [PW-1:0] BASE = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_spill,
  input  logic          start_fill,
  input  logic [QW-1:0] spill_data,
  input  logic          ptr_ld,
  input  logic [PW-1:0] ptr_ld_val,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [PW-1:0] mem_addr,
  output logic [QW-1:0] mem_wdata,
  output logic          busy,
  output logic          spill_done,
  output logic          fill_done,
  output logic [PW-1:0] ptr_value
);

  mem_state_e    state;
  logic [PW-1:0] ptr_q;

  assign busy       = (state != MS_IDLE);
  assign spill_done = (state == MS_SPILL) && mem_ack;
  assign fill_done  = (state == MS_FILL) && mem_ack;
  assign ptr_value  = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ptr_q     <= BASE;
    end else begin
      case (state)
        MS_IDLE: begin
          if (start_spill) begin
            state     <= MS_SPILL;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ptr_q;
            mem_wdata <= spill_data;
          end else if (start_fill) begin
            state    <= MS_FILL;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ptr_q - PW'(QBYTES);
          end else if (ptr_ld) begin
            ptr_q <= ptr_ld_val;
          end
        end
        MS_SPILL: begin
          if (mem_ack) begin
            state   <= MS_IDLE;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            ptr_q   <= ptr_q + PW'(QBYTES);
          end
        end
        MS_FILL: begin
          if (mem_ack) begin
            state   <= MS_IDLE;
            mem_req <= 1'b0;
            ptr_q   <= ptr_q - PW'(QBYTES);
          end
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/retstack_spill.sv
module retstack_spill
  import retstack_pkg::*;
#(
  parameter int            AW    = 32,
  parameter int            QW    = 128,
  parameter int            DEPTH = 4,
  parameter int            PW    = 32,
  parameter logic [PW-1:0] BASE  = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          use_link,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] pop_addr,
  output logic          pop_valid,
  output logic          collide_err,
  output logic          busy,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_load_val,
  output logic [PW-1:0] ptr_value,
  output logic          mem_req,
  output logic          mem_we,
  output logic [PW-1:0] mem_addr,
  output logic [QW-1:0] mem_wdata,
  input  logic [QW-1:0] mem_rdata,
  input  logic          mem_ack
);

  localparam int QE     = QW / AW;
  localparam int QBYTES = QW / 8;

  lifo_op_e      lop;
  logic          st_full, st_empty;
  logic [AW-1:0] st_top;
  logic [QW-1:0] st_quad;
  logic          spill_done, fill_done;
  logic          free, take_pop, take_push, take_ld;
  logic          stk_pop, stk_push, go_spill, go_fill;
  logic [AW-1:0] pend_q;
  logic [AW-1:0] link_q;
  logic [AW-1:0] lifo_in;

  // request acceptance: pointer load blocks stack traffic, pop beats push
  assign free      = !busy;
  assign take_ld   = free && ptr_load;
  assign take_pop  = free && pop_req && !ptr_load;
  assign take_push = free && push_req && !pop_req && !ptr_load;
  assign stk_pop   = take_pop && !use_link;
  assign stk_push  = take_push && !use_link;
  assign go_fill   = stk_pop && st_empty;
  assign go_spill  = stk_push && st_full;
  assign lifo_in   = spill_done ? pend_q : push_addr;

  always_comb begin
    if (spill_done)                lop = LOP_SPILL_PUSH;
    else if (fill_done)            lop = LOP_FILL_POP;
    else if (stk_push && !st_full) lop = LOP_PUSH;
    else if (stk_pop && !st_empty) lop = LOP_POP;
    else                           lop = LOP_NONE;
  end

  retstack_lifo #(
    .AW(AW), .DEPTH(DEPTH), .QE(QE)
  ) i_lifo (
    .clk(clk), .rst(rst), .op(lop), .push_val(lifo_in),
    .fill_quad(mem_rdata), .top_val(st_top), .spill_quad(st_quad),
    .full(st_full), .empty(st_empty)
  );

  retstack_mem_fsm #(
    .QW(QW), .PW(PW), .QBYTES(QBYTES), .BASE(BASE)
  ) i_mem (
    .clk(clk), .rst(rst), .start_spill(go_spill), .start_fill(go_fill),
    .spill_data(st_quad), .ptr_ld(take_ld), .ptr_ld_val(ptr_load_val),
    .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .spill_done(spill_done), .fill_done(fill_done), .ptr_value(ptr_value)
  );

  // pending push address waits out the spill
  always_ff @(posedge clk) begin
    if (rst)           pend_q <= '0;
    else if (go_spill) pend_q <= push_addr;
  end

  // registered results and link target
  always_ff @(posedge clk) begin
    if (rst) begin
      pop_addr    <= '0;
      pop_valid   <= 1'b0;
      collide_err <= 1'b0;
      link_q      <= '0;
    end else begin
      pop_valid   <= 1'b0;
      collide_err <= free && push_req && pop_req && !ptr_load;
      if (take_pop && use_link) begin
        pop_addr  <= link_q;
        pop_valid <= 1'b1;
      end else if (stk_pop && !st_empty) begin
        pop_addr  <= st_top;
        pop_valid <= 1'b1;
      end
      if (fill_done) begin
        pop_addr  <= mem_rdata[QW-1 -: AW];
        pop_valid <= 1'b1;
      end
      if (take_push && use_link) begin
        link_q <= push_addr;
      end
    end
  end

endmodule

// File: rtl/retstack_spill_chk.sv
module retstack_spill_chk #(
  parameter int PW     = 32,
  parameter int QBYTES = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          push_req,
  input logic          pop_req,
  input logic          pop_valid,
  input logic          collide_err,
  input logic          busy,
  input logic          ptr_load,
  input logic [PW-1:0] ptr_load_val,
  input logic [PW-1:0] ptr_value,
  input logic          mem_req,
  input logic          mem_we,
  input logic [PW-1:0] mem_addr,
  input logic          mem_ack
);

  assert_spill_ptr_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_we) |=> ptr_value == $past(ptr_value) + PW'(QBYTES));

  assert_fill_ptr_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=> ptr_value == $past(mem_addr));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_req_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_no_result_busy_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pop_valid);

  assert_collide_cause_R6: assert property (@(posedge clk) disable iff (rst)
    collide_err |-> $past(push_req && pop_req));

  assert_ptr_load_R8: assert property (@(posedge clk) disable iff (rst)
    (ptr_load && !busy) |=> ptr_value == $past(ptr_load_val));

endmodule

bind retstack_spill retstack_spill_chk #(
  .PW(PW), .QBYTES(QW / 8)
) i_retstack_spill_chk (
  .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
  .pop_valid(pop_valid), .collide_err(collide_err), .busy(busy),
  .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_value(ptr_value),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/test_retstack_spill.sv
module test_retstack_spill;

  localparam int          CLK_PERIOD = 10;
  localparam int          AW      = 32;
  localparam int          QW      = 128;
  localparam int          DEPTH   = 4;
  localparam int          PW      = 32;
  localparam logic [31:0] BASE    = 32'h0000_0100;
  localparam int          MEM_LAT = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_req = 1'b0, pop_req = 1'b0, use_link = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [AW-1:0] pop_addr;
  logic          pop_valid, collide_err, busy;
  logic          ptr_load = 1'b0;
  logic [PW-1:0] ptr_load_val = '0;
  logic [PW-1:0] ptr_value;
  logic          mem_req, mem_we;
  logic [PW-1:0] mem_addr;
  logic [QW-1:0] mem_wdata;
  logic [QW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  int n_chk = 0, n_bad = 0;
  int wr_count = 0, rd_count = 0, stall_cycles = 0, lat_cnt = 0;
  logic [PW-1:0] last_waddr = '0, last_raddr = '0;
  logic [QW-1:0] last_wdata = '0;
  logic [QW-1:0] mem [64];

  retstack_spill #(
    .AW(AW), .QW(QW), .DEPTH(DEPTH), .PW(PW), .BASE(BASE)
  ) i_retstack_spill (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .use_link(use_link), .push_addr(push_addr), .pop_addr(pop_addr),
    .pop_valid(pop_valid), .collide_err(collide_err), .busy(busy),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_value(ptr_value),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model, acknowledges MEM_LAT cycles after a request appears
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat_cnt == MEM_LAT) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[9:4]] <= mem_wdata;
          wr_count   <= wr_count + 1;
          last_waddr <= mem_addr;
          last_wdata <= mem_wdata;
        end else begin
          mem_rdata  <= mem[mem_addr[9:4]];
          rd_count   <= rd_count + 1;
          last_raddr <= mem_addr;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [QW-1:0] act,
                     input logic [QW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_until_taken();
    bit b;
    b = 1'b1;
    while (b) begin
      b = busy;
      @(negedge clk);
      if (b) stall_cycles++;
    end
    push_req = 1'b0;
    pop_req  = 1'b0;
    use_link = 1'b0;
  endtask

  task automatic do_push(input logic [AW-1:0] v, input bit lnk);
    @(negedge clk);
    push_req  = 1'b1;
    push_addr = v;
    use_link  = lnk;
    hold_until_taken();
  endtask

  task automatic do_pop(input logic [AW-1:0] exp, input bit lnk, input string tag,
                        output int lat);
    @(negedge clk);
    pop_req  = 1'b1;
    use_link = lnk;
    hold_until_taken();
    lat = 0;
    while (!pop_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(pop_valid === 1'b1 && pop_addr === exp, tag, pop_addr, exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic test_reset();
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(mem_req === 1'b0, "R1 mem_req", mem_req, 0);
    chk(pop_valid === 1'b0 && collide_err === 1'b0, "R1 valid/err",
        {pop_valid, collide_err}, 0);
    chk(ptr_value === BASE, "R1 ptr", ptr_value, BASE);
  endtask

  task automatic test_lifo();
    int lat;
    do_push(32'h11, 1'b0);
    do_push(32'h22, 1'b0);
    do_push(32'h33, 1'b0);
    do_pop(32'h33, 1'b0, "R2 pop 1", lat);
    chk(lat == 0, "R2 latency", lat, 0);
    do_pop(32'h22, 1'b0, "R2 pop 2", lat);
    do_pop(32'h11, 1'b0, "R2 pop 3", lat);
    chk(wr_count == 0 && ptr_value === BASE, "R2 no spill", ptr_value, BASE);
  endtask

  task automatic test_collide();
    int lat;
    do_push(32'hC0, 1'b0);
    do_push(32'hC1, 1'b0);
    @(negedge clk);
    push_req = 1'b1; pop_req = 1'b1; push_addr = 32'hCC;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    chk(pop_valid === 1'b1 && pop_addr === 32'hC1, "R6 pop wins", pop_addr, 32'hC1);
    chk(collide_err === 1'b1, "R6 err flag", collide_err, 1);
    @(negedge clk);
    chk(collide_err === 1'b0, "R6 err one cycle", collide_err, 0);
    do_pop(32'hC0, 1'b0, "R6 push discarded", lat);
  endtask

  task automatic test_link();
    int lat;
    do_push(32'h50, 1'b0);
    do_push(32'h51, 1'b0);
    do_push(32'h7E, 1'b1);
    do_pop(32'h7E, 1'b1, "R7 link pop", lat);
    do_pop(32'h51, 1'b0, "R7 stack intact 1", lat);
    do_pop(32'h50, 1'b0, "R7 stack intact 2", lat);
    chk(wr_count == 0 && rd_count == 0 && ptr_value === BASE, "R7 no memory",
        ptr_value, BASE);
  endtask

  task automatic test_spill_fill();
    int lat;
    for (int i = 0; i < 6; i++) do_push(32'hA0 + i, 1'b0);
    wait_idle();
    chk(wr_count == 1, "R3 one write", wr_count, 1);
    chk(last_waddr === BASE, "R3 write addr", last_waddr, BASE);
    chk(last_wdata === {32'hA3, 32'hA2, 32'hA1, 32'hA0}, "R3 packing",
        last_wdata, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    chk(ptr_value === BASE + 32'h10, "R3 ptr up", ptr_value, BASE + 32'h10);
    chk(stall_cycles > 0, "R5 push stalled", stall_cycles, 1);
    do_pop(32'hA5, 1'b0, "R3 pushed on top", lat);
    do_pop(32'hA4, 1'b0, "R5 stalled push kept", lat);
    do_pop(32'hA3, 1'b0, "R4 refill top", lat);
    chk(lat > 0, "R5 pop waits refill", lat, 1);
    chk(rd_count == 1 && last_raddr === BASE, "R4 read addr", last_raddr, BASE);
    chk(ptr_value === BASE, "R4 ptr down", ptr_value, BASE);
    do_pop(32'hA2, 1'b0, "R4 rest 1", lat);
    do_pop(32'hA1, 1'b0, "R4 rest 2", lat);
    do_pop(32'hA0, 1'b0, "R4 rest 3", lat);
    chk(rd_count == 1, "R4 single read", rd_count, 1);
  endtask

  task automatic test_deep();
    int lat;
    int w0;
    w0 = wr_count;
    for (int i = 0; i < 12; i++) do_push(32'hD00 + i, 1'b0);
    wait_idle();
    chk(wr_count == w0 + 2, "R9 two spills", wr_count, w0 + 2);
    chk(ptr_value === BASE + 32'h20, "R9 ptr deep", ptr_value, BASE + 32'h20);
    for (int i = 11; i >= 0; i--) do_pop(32'hD00 + i, 1'b0, "R9 order", lat);
    chk(ptr_value === BASE, "R9 ptr back", ptr_value, BASE);
  endtask

  task automatic test_ptr_load();
    int lat;
    @(negedge clk);
    ptr_load = 1'b1; ptr_load_val = 32'h200;
    @(negedge clk);
    ptr_load = 1'b0;
    chk(ptr_value === 32'h200, "R8 load", ptr_value, 32'h200);
    for (int i = 0; i < 5; i++) do_push(32'hE0 + i, 1'b0);
    wait_idle();
    chk(last_waddr === 32'h200, "R8 spill at loaded ptr", last_waddr, 32'h200);
    for (int i = 4; i >= 0; i--) do_pop(32'hE0 + i, 1'b0, "R8 order", lat);
    chk(ptr_value === 32'h200, "R8 ptr back", ptr_value, 32'h200);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_lifo();
    test_collide();
    test_link();
    test_spill_fill();
    test_deep();
    test_ptr_load();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule